// File: doc/BRIEF.md
# Refresh Command Pulse-Width Classifier

This block sits on the device side of a pseudo-static memory and watches two active-low inputs: the chip select and a shared control line. While the chip is selected, the control line is an output enable and the block ignores it. While the chip is deselected, a low pulse on the control line is a refresh command. The block tells the two kinds of refresh command apart only by how long the line stays low. A short pulse refreshes exactly one row. A long pulse puts the block into self refresh, where an internal timer paces the row refreshes until the line rises again.

An 11-bit row counter supplies the row to refresh, so callers never provide one. Each refresh is announced by a one-cycle strobe, and the row number is presented during that cycle. Refresh is accepted only after the control line has been seen high with the chip deselected. A line that is still low when an access ends therefore starts nothing. Two kinds of misuse raise a one-cycle violation pulse: a pulse too short to complete a refresh, and disturbing the lines during the guard interval after self refresh ends. Both inputs are assumed to be already synchronous to `clk`. All time limits are given in clock cycles.

Top module: `refresh_pulse_classifier`

## Requirements
- R1: While `sel_n` is low, activity on `cmd_n` produces no strobe, does not move the row counter and never enters self refresh.
- R2: If `cmd_n` is already low when `sel_n` rises, no refresh starts, however long it stays low. Refresh is accepted only after `cmd_n` has been sampled high with `sel_n` high.
- R3: A low pulse of k sampled cycles, with MIN_CYC <= k < LONG_CYC, gives exactly one `row_strobe`. The strobe is high in the cycle after the first high sample of `cmd_n`.
- R4: During a strobe, `row_addr` is the row being refreshed. The counter then advances by one and wraps from 2047 to 0. Without a strobe it holds.
- R5: A low pulse that reaches LONG_CYC sampled cycles raises `self_active`, with a strobe in that same cycle. While `cmd_n` stays low, a further strobe follows every PERIOD_CYC cycles.
- R6: The first high sample of `cmd_n` during self refresh clears `self_active` on the next cycle and issues no strobe.
- R7: After self refresh ends, both lines must stay high for RECOVER_CYC sampled cycles. A low sample of `cmd_n` or `sel_n` inside that window raises `violation` for one cycle, and that falling edge starts no refresh.
- R8: A low pulse shorter than MIN_CYC cycles raises `violation` for one cycle and gives no strobe.
- R9: After a synchronous reset (`rst_n` low), `row_strobe`, `self_active` and `violation` are low, and `row_addr` is 0.
- R10: Once the guard interval after self refresh has passed, the next short pulse is accepted as a normal one-row refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low (high = deselected) |
| cmd_n | input | 1 | Shared line: output enable while selected, refresh command while deselected |
| row_strobe | output | 1 | One-cycle pulse per row refresh |
| row_addr | output | ROW_BITS | Row being refreshed; valid during `row_strobe` |
| self_active | output | 1 | High while in self refresh |
| violation | output | 1 | One-cycle pulse on a protocol violation |

## Verification
The hardest situation to reach is a falling edge of the control line inside the guard window that follows self refresh. To get there, the line must first be held low past the long-pulse threshold, then released for fewer cycles than the guard interval, and then dropped again. The bench builds exactly that sequence. It also builds the same sequence with the select line dropped instead of the control line. A second hard-to-reach state is the row counter wrapping from 2047 to 0. The bench drives minimum-width pulses until the counter reaches the last row, then issues one more pulse and checks that the counter wraps to 0.

// File: rtl/rpc_pkg.sv
// Package: shared state encoding for the refresh pulse classifier.
// Assumes nothing beyond being compiled before the modules that import it.
package rpc_pkg;

    // Controller phases of the shared command line while deselected.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // disarmed: waiting for both lines high
        ST_ARMED   = 3'd1,  // armed: next low sample starts a pulse
        ST_PULSE   = 3'd2,  // measuring a low pulse
        ST_SELF    = 3'd3,  // timer-paced refresh
        ST_RECOVER = 3'd4   // guard interval after self refresh
    } rpc_state_e;

endpackage

// File: rtl/rpc_span_counter.sv
// Module: rpc_span_counter
// Counts enabled cycles from 0 to LIMIT-1, then wraps to 0. at_end marks
// the last count. Assumes LIMIT >= 2. Clear has priority over enable.
module rpc_span_counter #(
    parameter int LIMIT = 8,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         at_end
);

    // Last value before the wrap.
    assign at_end = (count == W'(LIMIT - 1));

    // Cycle counter with synchronous clear and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (en)     count <= at_end ? '0 : count + W'(1);
    end

endmodule

// File: rtl/rpc_row_counter.sv
// Module: rpc_row_counter
// Holds the row that the next refresh will use. Steps by one when a
// refresh has been issued and wraps naturally at 2**ROW_BITS.
// Assumes advance is a single-cycle pulse per refreshed row.
module rpc_row_counter #(
    parameter int ROW_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    output logic [ROW_BITS-1:0] row
);

    localparam int ROWS = 1 << ROW_BITS;
    localparam logic [ROW_BITS-1:0] LAST_ROW = ROW_BITS'(ROWS - 1);

    // Next-row pointer, wrapping from the last row to row 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       row <= '0;
        else if (advance) row <= (row == LAST_ROW) ? '0 : row + ROW_BITS'(1);
    end

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (row == ROW_BITS'($past(row) + ROW_BITS'(1))));

    // R4
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(row));

endmodule

// File: rtl/refresh_pulse_classifier.sv
// Module: refresh_pulse_classifier (top)
// Sorts low pulses on the shared command line, taken while the chip is
// deselected, into one-row refreshes and self refresh, by pulse width.
// Issues row strobes from an internal row counter and flags pulses that
// are too short and disturbances during the guard interval after self
// refresh. Assumes sel_n and cmd_n are synchronous to clk. Assumes
// 1 <= MIN_CYC < LONG_CYC, and RECOVER_CYC >= 2, PERIOD_CYC >= 2.
module refresh_pulse_classifier
    import rpc_pkg::*;
#(
    parameter int ROW_BITS    = 11,
    parameter int LONG_CYC    = 400,   // low samples that select self refresh
    parameter int MIN_CYC     = 4,     // shortest complete refresh pulse
    parameter int PERIOD_CYC  = 750,   // self-refresh strobe spacing
    parameter int RECOVER_CYC = 30     // high samples required after self refresh
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                cmd_n,
    output logic                row_strobe,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                self_active,
    output logic                violation
);

    localparam int WW = (LONG_CYC > 1) ? $clog2(LONG_CYC) : 1;
    localparam int PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam int RW = (RECOVER_CYC > 1) ? $clog2(RECOVER_CYC) : 1;

    rpc_state_e st, st_nxt;
    logic       strobe_d, viol_d;

    logic [WW-1:0] width_cnt;
    logic          width_end;
    logic [PW-1:0] tick_cnt;
    logic          tick_end;
    logic [RW-1:0] rec_cnt;
    logic          rec_end;
    logic [WW:0]   seen_lo;
    logic [RW:0]   seen_hi;

    // Measures low-pulse width while in the pulse phase.
    rpc_span_counter #(.LIMIT(LONG_CYC)) u_width (
        .clk(clk), .rst_n(rst_n),
        .clr(st != ST_PULSE), .en(st == ST_PULSE),
        .count(width_cnt), .at_end(width_end)
    );

    // Paces refresh strobes during self refresh.
    rpc_span_counter #(.LIMIT(PERIOD_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .clr(st != ST_SELF), .en(st == ST_SELF),
        .count(tick_cnt), .at_end(tick_end)
    );

    // Times the guard interval after self refresh.
    rpc_span_counter #(.LIMIT(RECOVER_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n),
        .clr(st != ST_RECOVER), .en(st == ST_RECOVER),
        .count(rec_cnt), .at_end(rec_end)
    );

    // Supplies the row for every strobe.
    rpc_row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .advance(row_strobe), .row(row_addr)
    );

    // Low samples so far, counting the entry sample; high samples in the guard.
    assign seen_lo = {1'b0, width_cnt} + (WW+1)'(1);
    assign seen_hi = {1'b0, rec_cnt} + (RW+1)'(2);

    // Next phase and the strobe or violation it implies.
    always_comb begin
        st_nxt   = st;
        strobe_d = 1'b0;
        viol_d   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (sel_n && cmd_n) st_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (!sel_n)      st_nxt = ST_IDLE;
                else if (!cmd_n) st_nxt = ST_PULSE;
            end
            ST_PULSE: begin
                if (!sel_n) begin
                    st_nxt = ST_IDLE;
                end else if (cmd_n) begin
                    st_nxt = ST_ARMED;
                    if (seen_lo < (WW+1)'(MIN_CYC)) viol_d   = 1'b1;
                    else                            strobe_d = 1'b1;
                end else if (seen_lo >= (WW+1)'(LONG_CYC - 1) || width_end) begin
                    st_nxt   = ST_SELF;
                    strobe_d = 1'b1;
                end
            end
            ST_SELF: begin
                if (!sel_n) begin
                    st_nxt = ST_IDLE;
                    viol_d = 1'b1;
                end else if (cmd_n) begin
                    st_nxt = ST_RECOVER;
                end else if (tick_end) begin
                    strobe_d = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (!sel_n || !cmd_n) begin
                    st_nxt = ST_IDLE;
                    viol_d = 1'b1;
                end else if (seen_hi >= (RW+1)'(RECOVER_CYC) || rec_end) begin
                    st_nxt = ST_ARMED;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Phase register and registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            row_strobe <= 1'b0;
            violation  <= 1'b0;
        end else begin
            st         <= st_nxt;
            row_strobe <= strobe_d;
            violation  <= viol_d;
        end
    end

    assign self_active = (st == ST_SELF);

    // R1
    sel_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |=> !row_strobe);

    // R5
    self_entry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_active) |-> row_strobe);

    // R6
    self_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (self_active && cmd_n) |=> (!self_active && !row_strobe));

    // R8
    viol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (!row_strobe && !self_active));

endmodule

// File: tb/refresh_pulse_classifier_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module refresh_pulse_classifier_bench;

    localparam int ROW_BITS = 11;
    localparam int LONG     = 40;
    localparam int MINW     = 4;
    localparam int PERIOD   = 25;
    localparam int REC      = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic cmd_n = 1'b1;
    logic                row_strobe;
    logic [ROW_BITS-1:0] row_addr;
    logic                self_active;
    logic                violation;

    int n_run = 0;
    int n_fail = 0;
    int n_strobe = 0;
    int n_viol = 0;
    int last_row = -1;
    int exp_row = 0;
    int cycles = 0;
    bit done = 1'b0;

    refresh_pulse_classifier #(
        .ROW_BITS(ROW_BITS), .LONG_CYC(LONG), .MIN_CYC(MINW),
        .PERIOD_CYC(PERIOD), .RECOVER_CYC(REC)
    ) u_refresh_pulse_classifier (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_n(cmd_n),
        .row_strobe(row_strobe), .row_addr(row_addr),
        .self_active(self_active), .violation(violation)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (row_strobe) begin
                n_strobe++;
                last_row = int'(row_addr);
            end
            if (violation) n_viol++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Low pulse of k sampled cycles, then time for the strobe to show.
    task automatic pulse(input int k);
        @(negedge clk) cmd_n = 1'b0;
        repeat (k) @(negedge clk);
        cmd_n = 1'b1;
        idle(3);
    endtask

    task automatic t_reset;
        chk("R9", "strobe", int'(row_strobe), 0);
        chk("R9", "row", int'(row_addr), 0);
        chk("R9", "self", int'(self_active), 0);
        chk("R9", "violation", int'(violation), 0);
    endtask

    task automatic t_short;
        int s0 = n_strobe;
        pulse(6);
        chk("R3", "strobes for k=6", n_strobe - s0, 1);
        chk("R4", "row at strobe", last_row, exp_row);
        exp_row = (exp_row + 1) % 2048;
        chk("R4", "row after", int'(row_addr), exp_row);
    endtask

    task automatic t_bounds;
        int s0 = n_strobe;
        int v0 = n_viol;
        pulse(MINW);
        chk("R3", "row at k=MIN", last_row, exp_row);
        exp_row = (exp_row + 1) % 2048;
        pulse(LONG - 1);
        chk("R3", "row at k=LONG-1", last_row, exp_row);
        exp_row = (exp_row + 1) % 2048;
        chk("R3", "strobes for two edge widths", n_strobe - s0, 2);
        chk("R3", "no violation", n_viol - v0, 0);
    endtask

    task automatic t_too_short;
        int s0 = n_strobe;
        int v0 = n_viol;
        pulse(MINW - 1);
        chk("R8", "violations", n_viol - v0, 1);
        chk("R8", "strobes", n_strobe - s0, 0);
        chk("R8", "row unchanged", int'(row_addr), exp_row);
    endtask

    task automatic t_selected;
        int s0 = n_strobe;
        @(negedge clk) sel_n = 1'b0;
        idle(2);
        pulse(6);
        pulse(LONG + 10);
        chk("R1", "self while selected", int'(self_active), 0);
        @(negedge clk) sel_n = 1'b1;
        idle(3);
        chk("R1", "strobes while selected", n_strobe - s0, 0);
        chk("R1", "row unchanged", int'(row_addr), exp_row);
    endtask

    task automatic t_arming;
        int s0 = n_strobe;
        @(negedge clk) sel_n = 1'b0;
        cmd_n = 1'b0;
        idle(3);
        sel_n = 1'b1;            // access ends with the line already low
        idle(LONG + 20);
        chk("R2", "self without arming", int'(self_active), 0);
        cmd_n = 1'b1;
        idle(3);
        chk("R2", "strobes without arming", n_strobe - s0, 0);
        pulse(6);
        chk("R2", "strobes after re-arm", n_strobe - s0, 1);
        chk("R2", "row at strobe", last_row, exp_row);
        exp_row = (exp_row + 1) % 2048;
    endtask

    task automatic t_self;
        int s0 = n_strobe;
        int v0 = n_viol;
        @(negedge clk) cmd_n = 1'b0;
        idle(60);
        chk("R5", "self active", int'(self_active), 1);
        idle(60);
        cmd_n = 1'b1;
        idle(3);
        chk("R5", "strobes in 120 low cycles", n_strobe - s0, 4);
        exp_row = (exp_row + 4) % 2048;
        chk("R5", "row after self", int'(row_addr), exp_row);
        chk("R6", "self cleared", int'(self_active), 0);
        idle(REC + 5);
        chk("R6", "no violation", n_viol - v0, 0);
        s0 = n_strobe;
        pulse(6);
        chk("R10", "strobe after guard", n_strobe - s0, 1);
        chk("R10", "row at strobe", last_row, exp_row);
        exp_row = (exp_row + 1) % 2048;
    endtask

    task automatic t_guard;
        int s0;
        int v0 = n_viol;
        pulse(LONG + 5);          // one entry strobe
        exp_row = (exp_row + 1) % 2048;
        s0 = n_strobe;
        idle(7);
        pulse(6);                 // falls inside the guard window
        chk("R7", "violation on early fall", n_viol - v0, 1);
        chk("R7", "no strobe from early fall", n_strobe - s0, 0);
        chk("R7", "row unchanged", int'(row_addr), exp_row);
        pulse(LONG + 5);
        exp_row = (exp_row + 1) % 2048;
        idle(5);
        @(negedge clk) sel_n = 1'b0;
        idle(3);
        sel_n = 1'b1;
        idle(3);
        chk("R7", "violation on select in guard", n_viol - v0, 2);
        s0 = n_strobe;
        pulse(6);
        chk("R10", "accepted after violation", n_strobe - s0, 1);
        exp_row = (exp_row + 1) % 2048;
    endtask

    task automatic t_wrap;
        while (exp_row != 2047) begin
            pulse(MINW);
            exp_row = exp_row + 1;
        end
        chk("R4", "row before wrap", int'(row_addr), 2047);
        pulse(MINW);
        chk("R4", "last row strobed", last_row, 2047);
        chk("R4", "wrapped to 0", int'(row_addr), 0);
        exp_row = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1'b1;
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    // Scenario sequence.
    initial begin
        idle(4);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        t_short();
        t_bounds();
        t_too_short();
        t_selected();
        t_arming();
        t_self();
        t_guard();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule